// File: doc/BRIEF.md
# Credit-return receiver with initialization

This block sits at the receiving end of a credit-control sideband and keeps the number of credits that a local consumer may spend. One instance serves one credit class, for example a header class with a 2-bit return count or a data class with a 4-bit return count. The sender opens an initialization phase by raising its init flag. While that flag is high, every update strobe adds its count to a fresh credit pool. The update strobe goes quiet at least two cycles before init falls. That gap is normal and raises no error.

When init falls, the receiver pulses its acknowledge for exactly one cycle and then enters normal operation. From then on, returned credits keep accumulating. A local consumer asks for N credits and is granted in the same cycle only when the pool holds at least N. A grant and a return in the same cycle are folded into one net adjustment. The pool saturates at a configurable ceiling and raises a sticky overflow flag when it does. If init rises again outside initialization, the pool restarts from that cycle's return.

Top module: `crd_rx_pool`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to its pre-init state: `pool_level` 0, and `crd_init_ack`, `pool_ready`, `pool_ovf` and `spend_gnt` all 0.
- R2: A cycle with `crd_init` high and `crd_upd` high adds `crd_upd_cnt` to the pool, and `pool_level` shows it after the next edge.
- R3: During initialization, cycles with `crd_init` high and `crd_upd` low leave the pool unchanged and raise no acknowledge, however many there are.
- R4: `crd_init_ack` is high for exactly one cycle: the cycle that follows the first cycle with `crd_init` low after initialization. `pool_ready` rises in the cycle after that.
- R5: `spend_gnt` stays 0 while `pool_ready` is 0. This holds in the pre-init state, during initialization and during the acknowledge cycle.
- R6: With `crd_init` low, a cycle with `crd_upd` high adds `crd_upd_cnt` to the pool, in any phase.
- R7: With `pool_ready` high and `crd_init` low, `spend_gnt` is high in the same cycle as `spend_req` exactly when `spend_amt` ≤ `pool_level`; a granted request subtracts `spend_amt` at the next edge. A refused request leaves the pool unchanged, and the equal case is granted.
- R8: A grant and a return in the same cycle give `pool_level` = old level − `spend_amt` + `crd_upd_cnt`.
- R9: `pool_level` never exceeds `POOL_MAX`. A result above it is clipped to `POOL_MAX` and sets `pool_ovf`, which then stays high until reset.
- R10: `crd_init` high outside initialization refuses any spend request in that cycle and restarts initialization. The pool is set to that cycle's return count, or 0 without one, and `pool_ready` drops.
- R11: A reset in normal operation returns the block to the pre-init state and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crd_init | input | 1 | Sender's initialization flag |
| crd_upd | input | 1 | Credit return strobe |
| crd_upd_cnt | input | CNT_W | Credits returned with the strobe |
| spend_req | input | 1 | Local consumer asks for credits |
| spend_amt | input | REQ_W | Number of credits asked for |
| spend_gnt | output | 1 | Request granted this cycle |
| crd_init_ack | output | 1 | One-cycle acknowledge that closes initialization |
| pool_level | output | POOL_W | Credits currently available |
| pool_ready | output | 1 | Normal operation, spends allowed |
| pool_ovf | output | 1 | Sticky saturation flag |

## Verification
The assertions check the invariants on every cycle. The acknowledge is never longer than one cycle and follows a cycle with init low. No grant appears without readiness. A granted amount is always covered by the pool, the pool stays at or below its ceiling, and the overflow flag, once set, stays set. The bench scenarios show the behaviour that depends on sequences of cycles. These are the build-up of the pool across the quiet gap before init falls, the exact cycle of the acknowledge and of readiness, the net adjustment when a spend and a return coincide, the refusal at one credit short against the grant at exactly enough, and the restart on a second init and on a mid-run reset.

// File: rtl/crd_rx_pkg.sv
// Shared phase encoding for the credit-return receiver.
package crd_rx_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INIT = 2'd1,
        PH_ACK  = 2'd2,
        PH_RUN  = 2'd3
    } crd_phase_e;
endpackage

// File: rtl/crd_rx_phase.sv
// Phase tracker: follows the sender's init flag through pre-init,
// initialization, the one-cycle acknowledge and normal operation.
// Assumes: init may rise again at any time; that restarts initialization.
module crd_rx_phase
    import crd_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    output logic start_o,
    output logic ack_o,
    output logic ready_o
);
    crd_phase_e state_q, state_d;

    // Next-phase selection from the current phase and the init flag.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PH_IDLE: if (init_i) state_d = PH_INIT;
            PH_INIT: if (!init_i) state_d = PH_ACK;
            PH_ACK:  state_d = init_i ? PH_INIT : PH_RUN;
            PH_RUN:  if (init_i) state_d = PH_INIT;
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    assign start_o = init_i && (state_q != PH_INIT);
    assign ack_o   = (state_q == PH_ACK);
    assign ready_o = (state_q == PH_RUN);

    // R4: acknowledge lasts a single cycle
    a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    // R4: acknowledge only follows a cycle with init low
    a_r4_ack_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !$past(init_i));
endmodule

// File: rtl/crd_rx_grant.sv
// Grant path: decides in the same cycle whether a spend request is
// covered by the pool and hands the amount to subtract to the counter.
// Assumes: the pool level is the registered value of this cycle.
module crd_rx_grant #(
    parameter int POOL_W = 8,
    parameter int REQ_W  = 4
) (
    input  logic              ready_i,
    input  logic              init_i,
    input  logic              req_i,
    input  logic [REQ_W-1:0]  amt_i,
    input  logic [POOL_W-1:0] level_i,
    output logic              gnt_o,
    output logic [POOL_W-1:0] sub_o
);
    logic [POOL_W-1:0] amt_ext;

    // Compare the widened request against the available credits.
    always_comb begin
        amt_ext = POOL_W'(amt_i);
        gnt_o   = ready_i && !init_i && req_i && (amt_ext <= level_i);
        sub_o   = gnt_o ? amt_ext : '0;
    end
endmodule

// File: rtl/crd_rx_counter.sv
// Pool counter: applies restart, return and spend as one net update,
// clips at the ceiling and keeps a sticky overflow flag.
// Assumes: sub_i never exceeds the current level and is 0 on restart.
module crd_rx_counter #(
    parameter int CNT_W    = 4,
    parameter int POOL_W   = 8,
    parameter int POOL_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              upd_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [POOL_W-1:0] sub_i,
    output logic [POOL_W-1:0] level_o,
    output logic              ovf_o
);
    localparam int SUM_W = POOL_W + 1;
    localparam logic [SUM_W-1:0] LIM = SUM_W'(POOL_MAX);

    logic [SUM_W-1:0]  add_ext, base, sum;
    logic [POOL_W-1:0] level_d;
    logic              clip;

    // Net adjustment: restart or (level - spend), plus return, then clip.
    always_comb begin
        add_ext = upd_i ? SUM_W'(cnt_i) : '0;
        base    = start_i ? '0 : (SUM_W'(level_o) - SUM_W'(sub_i));
        sum     = base + add_ext;
        clip    = (sum > LIM);
        level_d = clip ? POOL_W'(POOL_MAX) : sum[POOL_W-1:0];
    end

    // Level and sticky overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= '0;
            ovf_o   <= 1'b0;
        end else begin
            level_o <= level_d;
            ovf_o   <= ovf_o | clip;
        end
    end

    // R9: level never above the ceiling
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(level_o) <= LIM);
    // R9: overflow flag is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    // R7: a spend handed in is always covered by the pool
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_i != '0) |-> (sub_i <= level_o));
endmodule

// File: rtl/crd_rx_pool.sv
// Credit-return receiver for one credit class: builds the initial pool
// while init is high, acknowledges the end of init, then accumulates
// returns and grants local spends that the pool covers.
// Assumes: single clock domain; POOL_W is wide enough for CNT_W, REQ_W
// and POOL_MAX.
module crd_rx_pool #(
    parameter int CNT_W    = 4,
    parameter int REQ_W    = 4,
    parameter int POOL_W   = 8,
    parameter int POOL_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crd_init,
    input  logic              crd_upd,
    input  logic [CNT_W-1:0]  crd_upd_cnt,
    input  logic              spend_req,
    input  logic [REQ_W-1:0]  spend_amt,
    output logic              spend_gnt,
    output logic              crd_init_ack,
    output logic [POOL_W-1:0] pool_level,
    output logic              pool_ready,
    output logic              pool_ovf
);
    logic              start;
    logic [POOL_W-1:0] sub;

    crd_rx_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (crd_init),
        .start_o (start),
        .ack_o   (crd_init_ack),
        .ready_o (pool_ready)
    );

    crd_rx_grant #(.POOL_W(POOL_W), .REQ_W(REQ_W)) u_grant (
        .ready_i (pool_ready),
        .init_i  (crd_init),
        .req_i   (spend_req),
        .amt_i   (spend_amt),
        .level_i (pool_level),
        .gnt_o   (spend_gnt),
        .sub_o   (sub)
    );

    crd_rx_counter #(.CNT_W(CNT_W), .POOL_W(POOL_W), .POOL_MAX(POOL_MAX)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .upd_i   (crd_upd),
        .cnt_i   (crd_upd_cnt),
        .sub_i   (sub),
        .level_o (pool_level),
        .ovf_o   (pool_ovf)
    );

    // R5: no grant before normal operation
    a_r5_gnt_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        spend_gnt |-> pool_ready);
endmodule

// File: tb/test_crd_rx_pool.sv
`timescale 1ns/1ps
module test_crd_rx_pool;
    localparam int CNT_W    = 4;
    localparam int REQ_W    = 4;
    localparam int POOL_W   = 8;
    localparam int POOL_MAX = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic crd_init = 1'b0, crd_upd = 1'b0, spend_req = 1'b0;
    logic [CNT_W-1:0] crd_upd_cnt = '0;
    logic [REQ_W-1:0] spend_amt = '0;
    logic spend_gnt, crd_init_ack, pool_ready, pool_ovf;
    logic [POOL_W-1:0] pool_level;

    int checks = 0, errors = 0;
    int m_ph = 0, m_lvl = 0;
    bit m_ovf = 0;
    int    q_lvl[$];
    bit    q_ack[$], q_rdy[$], q_ovf[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    crd_rx_pool #(.CNT_W(CNT_W), .REQ_W(REQ_W), .POOL_W(POOL_W), .POOL_MAX(POOL_MAX)) i_crd_rx_pool (
        .clk(clk), .rst_n(rst_n), .crd_init(crd_init), .crd_upd(crd_upd),
        .crd_upd_cnt(crd_upd_cnt), .spend_req(spend_req), .spend_amt(spend_amt),
        .spend_gnt(spend_gnt), .crd_init_ack(crd_init_ack), .pool_level(pool_level),
        .pool_ready(pool_ready), .pool_ovf(pool_ovf)
    );

    task automatic push_exp(input string tag);
        q_lvl.push_back(m_lvl);
        q_ack.push_back(m_ph == 2);
        q_rdy.push_back(m_ph == 3);
        q_ovf.push_back(m_ovf);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops one expected item per cycle and compares registered outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (q_lvl.size() > 0) begin
                int e_lvl; bit e_ack, e_rdy, e_ovf; string tag;
                e_lvl = q_lvl.pop_front(); e_ack = q_ack.pop_front();
                e_rdy = q_rdy.pop_front(); e_ovf = q_ovf.pop_front();
                tag = q_tag.pop_front();
                checks++;
                if (int'(pool_level) !== e_lvl || crd_init_ack !== e_ack ||
                    pool_ready !== e_rdy || pool_ovf !== e_ovf) begin
                    errors++;
                    $display("FAIL %s: level/ack/ready/ovf got %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                             tag, pool_level, crd_init_ack, pool_ready, pool_ovf,
                             e_lvl, e_ack, e_rdy, e_ovf);
                end
            end
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; crd_init = 0; crd_upd = 0; spend_req = 0;
        @(posedge clk); @(posedge clk); #0.5;
        checks++;
        if (spend_gnt !== 1'b0) begin
            errors++;
            $display("FAIL %s: grant in reset got %0b expected 0", tag, spend_gnt);
        end
        m_ph = 0; m_lvl = 0; m_ovf = 0;
        push_exp(tag);
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Driver: one cycle of stimulus, same-cycle grant check, expected state pushed.
    task automatic step(input bit i, input bit u, input int c, input bit r,
                        input int a, input string tag);
        bit eg; int n;
        @(negedge clk);
        crd_init = i; crd_upd = u; crd_upd_cnt = c[CNT_W-1:0];
        spend_req = r; spend_amt = a[REQ_W-1:0];
        eg = (m_ph == 3) && !i && r && (a <= m_lvl);
        #0.5;
        checks++;
        if (spend_gnt !== eg) begin
            errors++;
            $display("FAIL %s: grant got %0b expected %0b", tag, spend_gnt, eg);
        end
        @(posedge clk); #0.5;
        if (i && m_ph != 1) begin
            m_lvl = u ? c : 0;
            m_ph = 1;
        end else begin
            n = m_lvl - (eg ? a : 0) + (u ? c : 0);
            if (n > POOL_MAX) begin n = POOL_MAX; m_ovf = 1; end
            m_lvl = n;
            if (m_ph == 1 && !i) m_ph = 2;
            else if (m_ph == 2) m_ph = 3;
        end
        push_exp(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): run still busy, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset("R1");
        step(0, 0, 0, 1, 0, "R5");          // idle spend refused
        step(1, 1, 5, 1, 1, "R2");          // init opens, +5
        step(1, 1, 3, 1, 1, "R2");          // +3 -> 8
        step(1, 0, 0, 1, 1, "R3");          // quiet gap
        step(1, 0, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 1, "R4");          // init low -> ack next
        step(0, 0, 0, 1, 1, "R5");          // ack cycle, refused
        step(0, 0, 0, 1, 3, "R7");          // ready: grant 3 -> 5
        step(0, 0, 0, 1, 6, "R7");          // one short: refused
        step(0, 0, 0, 1, 5, "R7");          // exactly enough -> 0
        step(0, 1, 7, 0, 0, "R6");          // return -> 7
        step(0, 1, 6, 1, 4, "R8");          // 7-4+6 -> 9
        step(0, 1, 15, 1, 10, "R8");        // refused, +15 -> 24
        for (int k = 0; k < 13; k++) step(0, 1, 15, 0, 0, "R9");
        step(0, 0, 0, 1, 10, "R9");         // 190, overflow still set
        step(1, 1, 4, 1, 1, "R10");         // restart: level 4, refused
        step(1, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 2, "R10");         // ack cycle, refused
        step(0, 0, 0, 1, 2, "R7");          // ready again: 4-2 -> 2
        do_reset("R11");
        step(0, 1, 3, 1, 1, "R11");         // pre-init: refused, +3
        step(1, 1, 2, 0, 0, "R10");         // new init discards old pool
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule